// File: doc/BRIEF.md
# Fast-Linking Settle Controller

This block runs one outer iteration of a pulse-coupled neuron row that uses fast linking. Each neuron arrives with its feeding value and its dynamic threshold, and the row arrives with the pulse image of the previous outer iteration. From that earlier image the block first forms an opening pulse image. It then keeps recomputing the linking sum, the internal activity and the pulse image from its own latest image, in passes of one clock each. It stops when a pass leaves every pulse unchanged. Only then does it decay and recharge the thresholds, using the settled image.

Because of this, linking waves can spread along the row further than one neighbour per outer iteration. The cost is that an outer iteration now takes a variable number of cycles. A pass limit bounds the run. Reaching the limit ends the run with a timeout flag in place of the settled flag. The number of inner passes is reported, and that report saturates. The surrounding sequencer loads the row, strobes start, and collects the pulse image and the new thresholds when done pulses.

Top module: `fl_settle_ctrl`

## Requirements
- R1: While reset is held and after it is released, busy, done, settled and timeout are 0, pass_cnt is 0, pulse_out is all zeros and theta_out is all zeros.
- R2: For a pulse image y, neuron i has link sum L = 1·y[i] + 2·y[i-1] + 2·y[i+1]. Neighbours beyond either end of the row count as 0. Its activity is U = F + floor(F·beta·L / 16), where beta is unsigned with 4 fraction bits. The neuron fires when U is strictly greater than its threshold.
- R3: The opening image is computed by R2 from pulse_prev. Each inner pass then computes a new image by R2 from the current image. The loop ends after the first pass whose result equals its input, and pulse_out shows the final image.
- R4: pass_cnt reports the number of inner passes in the run, including the final unchanged pass. It climbs by one per pass and holds at 63.
- R5: A run whose passes all change the image ends after pass_limit passes, with timeout=1 and settled=0. A pass_limit of 0 means 64 passes. If the pass that reaches the limit is also unchanged, the run counts as settled.
- R6: After the loop, each threshold becomes Θ − (Θ >> decay_sh) + (fired ? v_theta : 0), using the final image. The result is clamped at 1023 and appears on theta_out.
- R7: busy is 1 from the cycle after the edge that samples start until done. done is high for exactly one cycle, on the (P+3)-th rising edge when the sampling edge counts as the first and P is the pass count. busy is 0 with done.
- R8: A start strobe or a change of data inputs while busy does not alter the running iteration: results and latency match a run left undisturbed.
- R9: A run that settles ends with settled=1 and timeout=0. Both flags hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an outer iteration when idle |
| feed_in | input | N*F_W | Feeding value per neuron, neuron i at bits [i*F_W +: F_W] |
| theta_in | input | N*TH_W | Threshold per neuron, neuron i at bits [i*TH_W +: TH_W] |
| pulse_prev | input | N | Pulse image of the previous outer iteration |
| beta | input | BETA_W | Linking strength, FRAC fraction bits |
| v_theta | input | TH_W | Threshold recharge after a pulse |
| decay_sh | input | SH_W | Threshold decay shift |
| pass_limit | input | LIM_W | Maximum inner passes, 0 selects DEF_LIMIT |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion strobe |
| settled | output | 1 | Last run reached a fixed point |
| timeout | output | 1 | Last run stopped at the pass limit |
| pass_cnt | output | CNT_W | Inner passes of the current or last run, saturating |
| pulse_out | output | N | Final pulse image |
| theta_out | output | N*TH_W | Updated thresholds |

## Verification
Two things can happen on the same inner pass: the image can go quiet, and the pass limit can be reached. The quiet exit takes priority. To provoke this, a wave vector that settles on exactly its seventh pass runs with a limit of seven. A quiet opening image also runs with a limit of one. Both must end settled, while an oscillating pattern under a limit of one must end in timeout. A second overlap comes from a new start strobe that lands while the loop is running. That case is judged by comparing the results and the completion cycle with those of the same run left undisturbed.

// File: rtl/fl_pkg.sv
package fl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_LOOP = 2'd2,
    ST_THR  = 2'd3
  } fl_state_e;

  // weighted count of firing neighbours around one neuron
  function automatic int unsigned link_sum(input logic lft, input logic mid, input logic rgt,
                                           input int unsigned w_self, input int unsigned w_nb);
    int unsigned s;
    s = 32'd0;
    if (mid) s = s + w_self;
    if (lft) s = s + w_nb;
    if (rgt) s = s + w_nb;
    return s;
  endfunction

  // U = F * (1 + beta*L), beta carrying frac fraction bits
  function automatic int unsigned activity(input int unsigned f, input int unsigned b,
                                           input int unsigned l, input int unsigned frac);
    return f + ((f * b * l) >> frac);
  endfunction

  // decay plus recharge, clamped at ceil_v
  function automatic int unsigned theta_step(input int unsigned th, input int unsigned sh,
                                             input int unsigned vth, input logic fired,
                                             input int unsigned ceil_v);
    int unsigned s;
    s = th - (th >> sh);
    if (fired) s = s + vth;
    return (s > ceil_v) ? ceil_v : s;
  endfunction

endpackage

// File: rtl/fl_link_unit.sv
module fl_link_unit
  import fl_pkg::*;
#(
  parameter int N      = 8,
  parameter int F_W    = 8,
  parameter int TH_W   = 10,
  parameter int BETA_W = 8,
  parameter int FRAC   = 4,
  parameter int W_SELF = 1,
  parameter int W_NB   = 2
) (
  input  logic [N-1:0]      img,
  input  logic [N*F_W-1:0]  feed,
  input  logic [N*TH_W-1:0] theta,
  input  logic [BETA_W-1:0] beta,
  output logic [N-1:0]      nxt,
  output logic              changed
);

  for (genvar i = 0; i < N; i++) begin : g_neuron
    logic        lft;
    logic        rgt;
    int unsigned lsum;
    int unsigned act;

    if (i == 0) begin : g_lo_edge
      assign lft = 1'b0;
    end else begin : g_lo_mid
      assign lft = img[i-1];
    end

    if (i == N-1) begin : g_hi_edge
      assign rgt = 1'b0;
    end else begin : g_hi_mid
      assign rgt = img[i+1];
    end

    assign lsum   = link_sum(lft, img[i], rgt, W_SELF, W_NB);
    assign act    = activity(32'(feed[i*F_W +: F_W]), 32'(beta), lsum, FRAC);
    assign nxt[i] = act > 32'(theta[i*TH_W +: TH_W]);
  end

  assign changed = |(nxt ^ img);

endmodule

// File: rtl/fl_theta_unit.sv
module fl_theta_unit
  import fl_pkg::*;
#(
  parameter int N    = 8,
  parameter int TH_W = 10,
  parameter int SH_W = 3
) (
  input  logic [N*TH_W-1:0] theta,
  input  logic [N-1:0]      img,
  input  logic [SH_W-1:0]   sh,
  input  logic [TH_W-1:0]   vth,
  output logic [N*TH_W-1:0] theta_new
);

  localparam int unsigned TH_CEIL = (1 << TH_W) - 1;

  for (genvar i = 0; i < N; i++) begin : g_thr
    assign theta_new[i*TH_W +: TH_W] =
      TH_W'(theta_step(32'(theta[i*TH_W +: TH_W]), 32'(sh), 32'(vth), img[i], TH_CEIL));
  end

endmodule

// File: rtl/fl_pass_ctrl.sv
module fl_pass_ctrl
  import fl_pkg::*;
#(
  parameter int LIM_W     = 7,
  parameter int CNT_W     = 6,
  parameter int DEF_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LIM_W-1:0] limit_q,
  input  logic             changed,
  output logic             cap_en,
  output logic             step_en,
  output logic             pass_fire,
  output logic             thr_fire,
  output logic             busy,
  output logic             done,
  output logic             settled,
  output logic             timeout,
  output logic [CNT_W-1:0] pass_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [LIM_W-1:0] LIM_DEF = LIM_W'(DEF_LIMIT);

  fl_state_e        state;
  logic [LIM_W-1:0] npass;
  logic [LIM_W-1:0] lim_eff;
  logic             last_pass;
  logic             cause_to;

  assign lim_eff   = (limit_q == '0) ? LIM_DEF : limit_q;
  assign last_pass = ({1'b0, npass} + 1'b1) == {1'b0, lim_eff};

  assign cap_en    = (state == ST_IDLE) && start;
  assign pass_fire = (state == ST_LOOP);
  assign step_en   = (state == ST_INIT) || pass_fire;
  assign thr_fire  = (state == ST_THR);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      npass    <= '0;
      pass_cnt <= '0;
      done     <= 1'b0;
      settled  <= 1'b0;
      timeout  <= 1'b0;
      cause_to <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            settled <= 1'b0;
            timeout <= 1'b0;
            state   <= ST_INIT;
          end
        end
        ST_INIT: begin
          npass    <= '0;
          pass_cnt <= '0;
          state    <= ST_LOOP;
        end
        ST_LOOP: begin
          npass <= npass + 1'b1;
          if (pass_cnt != CNT_MAX) pass_cnt <= pass_cnt + 1'b1;
          if (!changed) begin
            cause_to <= 1'b0;
            state    <= ST_THR;
          end else if (last_pass) begin
            cause_to <= 1'b1;
            state    <= ST_THR;
          end
        end
        ST_THR: begin
          done    <= 1'b1;
          settled <= !cause_to;
          timeout <= cause_to;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fl_settle_ctrl.sv
module fl_settle_ctrl
  import fl_pkg::*;
#(
  parameter int N         = 8,
  parameter int F_W       = 8,
  parameter int TH_W      = 10,
  parameter int BETA_W    = 8,
  parameter int FRAC      = 4,
  parameter int SH_W      = 3,
  parameter int LIM_W     = 7,
  parameter int CNT_W     = 6,
  parameter int DEF_LIMIT = 64,
  parameter int W_SELF    = 1,
  parameter int W_NB      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [N*F_W-1:0]    feed_in,
  input  logic [N*TH_W-1:0]   theta_in,
  input  logic [N-1:0]        pulse_prev,
  input  logic [BETA_W-1:0]   beta,
  input  logic [TH_W-1:0]     v_theta,
  input  logic [SH_W-1:0]     decay_sh,
  input  logic [LIM_W-1:0]    pass_limit,
  output logic                busy,
  output logic                done,
  output logic                settled,
  output logic                timeout,
  output logic [CNT_W-1:0]    pass_cnt,
  output logic [N-1:0]        pulse_out,
  output logic [N*TH_W-1:0]   theta_out
);

  localparam int FEED_BITS = N * F_W;
  localparam int TH_BITS   = N * TH_W;

  logic [FEED_BITS-1:0] feed_q;
  logic [TH_BITS-1:0]   theta_q;
  logic [BETA_W-1:0]    beta_q;
  logic [TH_W-1:0]      vth_q;
  logic [SH_W-1:0]      sh_q;
  logic [LIM_W-1:0]     lim_q;
  logic [N-1:0]         img;

  // named internal events, observed by the bound checker
  logic                 cap_en;
  logic                 step_en;
  logic                 pass_fire;
  logic                 thr_fire;
  logic                 pass_changed;
  logic [N-1:0]         img_next;
  logic [TH_BITS-1:0]   theta_new;

  fl_link_unit #(
    .N(N), .F_W(F_W), .TH_W(TH_W), .BETA_W(BETA_W),
    .FRAC(FRAC), .W_SELF(W_SELF), .W_NB(W_NB)
  ) u_link (
    .img     (img),
    .feed    (feed_q),
    .theta   (theta_q),
    .beta    (beta_q),
    .nxt     (img_next),
    .changed (pass_changed)
  );

  fl_theta_unit #(
    .N(N), .TH_W(TH_W), .SH_W(SH_W)
  ) u_theta (
    .theta     (theta_q),
    .img       (img),
    .sh        (sh_q),
    .vth       (vth_q),
    .theta_new (theta_new)
  );

  fl_pass_ctrl #(
    .LIM_W(LIM_W), .CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .limit_q   (lim_q),
    .changed   (pass_changed),
    .cap_en    (cap_en),
    .step_en   (step_en),
    .pass_fire (pass_fire),
    .thr_fire  (thr_fire),
    .busy      (busy),
    .done      (done),
    .settled   (settled),
    .timeout   (timeout),
    .pass_cnt  (pass_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feed_q    <= '0;
      theta_q   <= '0;
      beta_q    <= '0;
      vth_q     <= '0;
      sh_q      <= '0;
      lim_q     <= '0;
      img       <= '0;
      pulse_out <= '0;
      theta_out <= '0;
    end else begin
      if (cap_en) begin
        feed_q  <= feed_in;
        theta_q <= theta_in;
        beta_q  <= beta;
        vth_q   <= v_theta;
        sh_q    <= decay_sh;
        lim_q   <= pass_limit;
        img     <= pulse_prev;
      end else if (step_en) begin
        img <= img_next;
      end
      if (thr_fire) begin
        pulse_out <= img;
        theta_out <= theta_new;
      end
    end
  end

endmodule

// File: rtl/fl_settle_chk.sv
module fl_settle_chk #(
  parameter int N     = 8,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             settled,
  input logic             timeout,
  input logic [CNT_W-1:0] pass_cnt,
  input logic [N-1:0]     pulse_out,
  input logic             pass_fire,
  input logic             pass_changed,
  input logic             thr_fire
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_thr_then_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_fire |=> (done && !busy));

  p_quiet_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_fire && !pass_changed) |=> thr_fire);

  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> !timeout);

  p_image_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !thr_fire) |=> $stable(pulse_out));

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_fire && pass_cnt != CNT_TOP) |=> (pass_cnt == CNT_W'($past(pass_cnt) + 1'b1)));

  p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_fire && pass_cnt == CNT_TOP) |=> (pass_cnt == CNT_TOP));

  p_timeout_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

endmodule

bind fl_settle_ctrl fl_settle_chk #(.N(N), .CNT_W(CNT_W)) u_fl_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .settled      (settled),
  .timeout      (timeout),
  .pass_cnt     (pass_cnt),
  .pulse_out    (pulse_out),
  .pass_fire    (pass_fire),
  .pass_changed (pass_changed),
  .thr_fire     (thr_fire)
);

// File: tb/test_fl_settle_ctrl.sv
module test_fl_settle_ctrl;

  localparam int N = 8;
  localparam int NV = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [N*8-1:0]    feed_in = '0;
  logic [N*10-1:0]   theta_in = '0;
  logic [N-1:0]      pulse_prev = '0;
  logic [7:0]        beta = '0;
  logic [9:0]        v_theta = '0;
  logic [2:0]        decay_sh = '0;
  logic [6:0]        pass_limit = '0;
  logic              busy, done, settled, timeout;
  logic [5:0]        pass_cnt;
  logic [N-1:0]      pulse_out;
  logic [N*10-1:0]   theta_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fl_settle_ctrl #(
    .N(N), .F_W(8), .TH_W(10), .BETA_W(8), .FRAC(4), .SH_W(3),
    .LIM_W(7), .CNT_W(6), .DEF_LIMIT(64), .W_SELF(1), .W_NB(2)
  ) i_fl_settle_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .feed_in(feed_in), .theta_in(theta_in),
    .pulse_prev(pulse_prev), .beta(beta), .v_theta(v_theta), .decay_sh(decay_sh),
    .pass_limit(pass_limit), .busy(busy), .done(done), .settled(settled),
    .timeout(timeout), .pass_cnt(pass_cnt), .pulse_out(pulse_out), .theta_out(theta_out)
  );

  // stimulus columns plus expected pass count and timeout
  localparam logic [N*8-1:0] T_F [NV] = '{
    {8{8'd10}}, {8{8'd10}}, {8{8'd10}}, {8{8'd10}},
    {8{8'd10}}, {8{8'd10}}, {8{8'd255}}, {8{8'd10}} };
  localparam logic [N*10-1:0] T_TH [NV] = '{
    {8{10'd5}}, {8{10'd15}}, {8{10'd25}}, {8{10'd25}},
    {8{10'd5}}, {8{10'd25}}, {{6{10'd1000}}, 10'd100, 10'd1020}, {8{10'd15}} };
  localparam logic [N-1:0] T_PREV [NV] = '{
    8'h00, 8'h01, 8'h55, 8'h55, 8'h00, 8'h55, 8'h00, 8'h01 };
  localparam logic [7:0] T_B   [NV] = '{ 8'd16, 8'd16, 8'd16, 8'd16, 8'd16, 8'd16, 8'd255, 8'd16 };
  localparam logic [9:0] T_VTH [NV] = '{ 10'd20, 10'd20, 10'd5, 10'd5, 10'd20, 10'd5, 10'd20, 10'd9 };
  localparam logic [2:0] T_SH  [NV] = '{ 3'd2, 3'd3, 3'd1, 3'd1, 3'd2, 3'd1, 3'd7, 3'd0 };
  localparam logic [6:0] T_LIM [NV] = '{ 7'd10, 7'd0, 7'd5, 7'd0, 7'd1, 7'd1, 7'd0, 7'd7 };
  localparam int         T_PASS[NV] = '{ 1, 7, 5, 64, 1, 1, 7, 7 };
  localparam bit         T_TO  [NV] = '{ 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0 };

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_step(input logic [N-1:0] y, input logic [N*8-1:0] f,
                                          input logic [N*10-1:0] th, input int b);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      longint l = 0;
      longint u;
      if (y[i]) l = l + 1;
      if (i > 0 && y[i-1]) l = l + 2;
      if (i < N-1 && y[i+1]) l = l + 2;
      u = longint'(f[i*8 +: 8]);
      u = u + (u * b * l) / 16;
      r[i] = u > longint'(th[i*10 +: 10]);
    end
    return r;
  endfunction

  task automatic model(input int k, output logic [N-1:0] fy, output logic [N*10-1:0] fth);
    logic [N-1:0] y, n;
    int lim, p;
    lim = (T_LIM[k] == 0) ? 64 : int'(T_LIM[k]);
    y = m_step(T_PREV[k], T_F[k], T_TH[k], int'(T_B[k]));
    p = 0;
    while (1) begin
      n = m_step(y, T_F[k], T_TH[k], int'(T_B[k]));
      p++;
      if (n == y) break;
      y = n;
      if (p >= lim) break;
    end
    fy = y;
    for (int i = 0; i < N; i++) begin
      longint t = longint'(T_TH[k][i*10 +: 10]);
      t = t - t / (longint'(1) << T_SH[k]);
      if (y[i]) t = t + longint'(T_VTH[k]);
      if (t > 1023) t = 1023;
      fth[i*10 +: 10] = 10'(t);
    end
  endtask

  task automatic drive(input int k);
    feed_in = T_F[k]; theta_in = T_TH[k]; pulse_prev = T_PREV[k];
    beta = T_B[k]; v_theta = T_VTH[k]; decay_sh = T_SH[k]; pass_limit = T_LIM[k];
  endtask

  task automatic run_vec(input int k, input int intf);
    logic [N-1:0]    ey;
    logic [N*10-1:0] eth;
    int cyc;
    bit seen;
    int ecnt;
    model(k, ey, eth);
    ecnt = (T_PASS[k] > 63) ? 63 : T_PASS[k];
    @(negedge clk);
    drive(k);
    start = 1'b1;
    cyc = 0;
    seen = 0;
    while (!seen && cyc < 500) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = 1'b0;
      if (cyc == 1) begin
        chk(busy == 1'b1, "R7 busy after start", 128'(busy), 128'(1));
        chk(!settled && !timeout, "R9 flags cleared by start", 128'({settled, timeout}), 128'(0));
      end
      if (intf >= 0 && cyc == 10) begin
        drive(intf);
        start = 1'b1;
      end
      if (done) seen = 1;
    end
    chk(seen && cyc == T_PASS[k] + 3, "R7 done latency", 128'(cyc), 128'(T_PASS[k] + 3));
    chk(busy == 1'b0, "R7 busy low with done", 128'(busy), 128'(0));
    chk(pulse_out == ey, "R3 R2 settled pulse image", 128'(pulse_out), 128'(ey));
    chk(pass_cnt == 6'(ecnt), "R4 pass count", 128'(pass_cnt), 128'(ecnt));
    chk(timeout == T_TO[k], "R5 timeout flag", 128'(timeout), 128'(T_TO[k]));
    chk(settled == !T_TO[k], "R9 settled flag", 128'(settled), 128'(!T_TO[k]));
    chk(theta_out == eth, "R6 threshold update", 128'(theta_out), 128'(eth));
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 128'(done), 128'(0));
    repeat (2) @(negedge clk);
    chk(settled == !T_TO[k] && timeout == T_TO[k], "R9 flags held",
        128'({settled, timeout}), 128'({!T_TO[k], T_TO[k]}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !settled && !timeout, "R1 flags in reset",
        128'({busy, done, settled, timeout}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(pass_cnt == 0 && pulse_out == 0 && theta_out == 0, "R1 data after reset",
        128'({pass_cnt, pulse_out}), 128'(0));
    chk(!busy && !done, "R1 idle after reset", 128'({busy, done}), 128'(0));

    for (int k = 0; k < NV; k++) run_vec(k, -1);

    // R8: start strobe and new data land mid-loop of the 64-pass run
    run_vec(3, 0);
    // R8: idle run afterwards still uses its own data
    run_vec(1, -1);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule